// File: doc/BRIEF.md
# Memory Protection Unit Register Bank

This block is the register bank that software uses to program a memory protection unit with up to sixteen regions. A word-wide register bus with an address, a write strobe, write data and combinational read data gives access to a read-only type word, a control word, a region-number selector, and, for each region, a base-address word and an attribute/size word. The region-specific words are reached indirectly through the region-number selector, and the base and attribute pair appears at four addresses that all map onto the same storage.

A base write whose valid bit is set carries its own region index. That index selects the region and is also copied into the region-number selector. Accesses that would reach a region beyond the configured count are dropped without effect. Reads to such a region return zero. The block drives the stored control bits and every region's settings as plain outputs for the address-checking logic, which lies outside this block. It also drives a one-cycle pulse that tells translation caches to invalidate, and a one-cycle error pulse when software writes an illegal control setting.

The register bus is a plain register port with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Reads have no wait state and reflect the registered state for the current `bus_addr`. NUM_REGIONS must lie between 1 and 16.

Top module: `mpu_regbank`

## Requirements
- R1: After reset, the control bits, the region number and every region's base, size and access fields are zero, and both pulses are low.
- R2: The type word at 0xD90 reads NUM_REGIONS in bits [15:8] and zero elsewhere (0x0000_0800 for 8 regions). Writes to it change no state and raise no flush pulse.
- R3: The control word at 0xD94 stores only written bits [2:0]: enable in bit 0, fault-handler enable in bit 1 and privileged default map in bit 2. It reads back as those three bits with zeros above, and it drives `mpu_enable`, `mpu_fault_en` and `mpu_privdef_en`.
- R4: A control write whose bit 1 is 1 and bit 0 is 0 is still stored. It also makes `illegal_pulse` high for exactly the one cycle after the write edge.
- R5: A write to the region-number word at 0xD98 with a 32-bit value below NUM_REGIONS stores that value. A value of NUM_REGIONS or more is ignored and the previous value reads back.
- R6: When a base-view write has bit 4 (valid) set, bits [3:0] name the target region and are also stored as the region number. If that index is NUM_REGIONS or more, the whole write is dropped: no region number change, no base change and no flush.
- R7: A base-view write with bit 4 clear targets the current region number. The stored base is the written word with bits [4:0] zero. A base-view read returns the stored bits [31:5], zero in bit 4 and the current region number in bits [3:0].
- R8: An attribute-view write stores bits [15:0] AND 0xFF3F as the size field and bits [31:16] AND 0x173F as the access field of the current region. A read returns the access field in [31:16] and the size field in [15:0].
- R9: The base views at 0xD9C, 0xDA4, 0xDAC and 0xDB4, and the attribute views at 0xDA0, 0xDA8, 0xDB0 and 0xDB8, behave identically and share storage.
- R10: Every accepted write to the control, base or attribute words makes `flush_pulse` high for the one cycle after the write edge. Dropped writes and writes to other addresses do not.
- R11: Unmapped addresses read zero, and writes to them change no output and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| mpu_enable | output | 1 | Stored control enable bit |
| mpu_fault_en | output | 1 | Stored fault-handler enable bit |
| mpu_privdef_en | output | 1 | Stored privileged default map bit |
| region_base | output | NUM_REGIONS*32 | Base words, region r in bits [r*32 +: 32] |
| region_size | output | NUM_REGIONS*16 | Size/enable fields, region r in [r*16 +: 16] |
| region_access | output | NUM_REGIONS*16 | Access-control fields, region r in [r*16 +: 16] |
| flush_pulse | output | 1 | One-cycle translation invalidate |
| illegal_pulse | output | 1 | One-cycle illegal control setting error |

## Verification
A valid-bit base write changes two things at one edge: the region-number selector and one region's base entry. An out-of-range index must suppress both and also the flush pulse. Directed writes cover in-range and out-of-range indices through different alias views, and a pseudo-random stream adds many more. A behavioural model in the bench is compared against every output and the read data on each clock. An illegal control write also raises the error and flush pulses in the same cycle, and both pulses are compared on every clock against the model.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_TYPE, K_CTRL, K_RNR, K_BASE, K_ATTR
  } reg_kind_e;

  localparam int          RN_W        = 4;
  localparam int          VALID_BIT   = 4;
  localparam int          VIEW_STRIDE = 8;
  localparam int          NUM_VIEWS   = 4;
  localparam logic [11:0] OFS_TYPE    = 12'hD90;
  localparam logic [11:0] OFS_CTRL    = 12'hD94;
  localparam logic [11:0] OFS_RNR     = 12'hD98;
  localparam logic [11:0] OFS_VIEW0   = 12'hD9C;
  localparam logic [15:0] SIZE_KEEP   = 16'hFF3F;
  localparam logic [15:0] ACC_KEEP    = 16'h173F;
endpackage

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
  import mpu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind
);
  always_comb begin
    kind = K_NONE;
    if (addr == ADDR_W'(OFS_TYPE)) kind = K_TYPE;
    if (addr == ADDR_W'(OFS_CTRL)) kind = K_CTRL;
    if (addr == ADDR_W'(OFS_RNR))  kind = K_RNR;
    for (int v = 0; v < NUM_VIEWS; v++) begin
      if (addr == ADDR_W'(OFS_VIEW0) + ADDR_W'(v * VIEW_STRIDE))     kind = K_BASE;
      if (addr == ADDR_W'(OFS_VIEW0) + ADDR_W'(v * VIEW_STRIDE + 4)) kind = K_ATTR;
    end
  end
endmodule

// File: rtl/mpu_ctrl_regs.sv
module mpu_ctrl_regs
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  reg_kind_e       kind,
  input  logic            wr,
  input  logic [31:0]     wdata,
  output logic [2:0]      ctrl_q,
  output logic [RN_W-1:0] rnr_q,
  output logic            rnr_ok,
  output logic [RN_W-1:0] wr_idx,
  output logic            base_we,
  output logic            attr_we,
  output logic            flush_q,
  output logic            illegal_q
);
  localparam logic [RN_W:0] NREG = (RN_W+1)'(NUM_REGIONS);

  logic            use_own_idx;
  logic [RN_W-1:0] base_idx;
  logic            base_idx_ok;
  logic            ctrl_we;
  logic            rnr_we;

  assign use_own_idx = wdata[VALID_BIT];
  assign base_idx    = use_own_idx ? wdata[RN_W-1:0] : rnr_q;
  assign base_idx_ok = {1'b0, base_idx} < NREG;
  assign rnr_ok      = {1'b0, rnr_q} < NREG;

  assign ctrl_we = wr && (kind == K_CTRL);
  assign rnr_we  = wr && (kind == K_RNR) && (wdata < 32'(NUM_REGIONS));
  assign base_we = wr && (kind == K_BASE) && base_idx_ok;
  assign attr_we = wr && (kind == K_ATTR) && rnr_ok;
  assign wr_idx  = (kind == K_BASE) ? base_idx : rnr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rnr_q     <= '0;
      flush_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata[2:0];
      if (rnr_we) rnr_q <= wdata[RN_W-1:0];
      else if (base_we && use_own_idx) rnr_q <= wdata[RN_W-1:0];
      flush_q   <= ctrl_we || base_we || attr_we;
      illegal_q <= ctrl_we && wdata[1] && !wdata[0];
    end
  end

  assert_rnr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, rnr_q} < NREG);

  assert_rnr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == K_RNR && wdata >= 32'(NUM_REGIONS)) |=> $stable(rnr_q));

  assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind == K_CTRL) |=> (ctrl_q == $past(wdata[2:0])));
endmodule

// File: rtl/mpu_region_file.sv
module mpu_region_file
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      base_we,
  input  logic                      attr_we,
  input  logic [RN_W-1:0]           wr_idx,
  input  logic [31:0]               wdata,
  input  logic [RN_W-1:0]           rd_idx,
  output logic [31:0]               rd_base,
  output logic [15:0]               rd_size,
  output logic [15:0]               rd_acc,
  output logic [NUM_REGIONS*32-1:0] base_all,
  output logic [NUM_REGIONS*16-1:0] size_all,
  output logic [NUM_REGIONS*16-1:0] acc_all
);
  logic [31:0] base_q [NUM_REGIONS];
  logic [15:0] size_q [NUM_REGIONS];
  logic [15:0] acc_q  [NUM_REGIONS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (!rst_n) begin
        base_q[r] <= '0;
        size_q[r] <= '0;
        acc_q[r]  <= '0;
      end else if (wr_idx == RN_W'(r)) begin
        if (base_we) base_q[r] <= {wdata[31:5], 5'b0};
        if (attr_we) begin
          size_q[r] <= wdata[15:0] & SIZE_KEEP;
          acc_q[r]  <= wdata[31:16] & ACC_KEEP;
        end
      end
    end
  end

  always_comb begin
    rd_base = '0;
    rd_size = '0;
    rd_acc  = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (rd_idx == RN_W'(r)) begin
        rd_base = base_q[r];
        rd_size = size_q[r];
        rd_acc  = acc_q[r];
      end
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_flat
    assign base_all[g*32 +: 32] = base_q[g];
    assign size_all[g*16 +: 16] = size_q[g];
    assign acc_all[g*16 +: 16]  = acc_q[g];
  end

  assert_base_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (rd_base[4:0] == 5'b0));
endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      mpu_enable,
  output logic                      mpu_fault_en,
  output logic                      mpu_privdef_en,
  output logic [NUM_REGIONS*32-1:0] region_base,
  output logic [NUM_REGIONS*16-1:0] region_size,
  output logic [NUM_REGIONS*16-1:0] region_access,
  output logic                      flush_pulse,
  output logic                      illegal_pulse
);
  localparam logic [RN_W:0] NREG = (RN_W+1)'(NUM_REGIONS);

  reg_kind_e       kind;
  logic [2:0]      ctrl_q;
  logic [RN_W-1:0] rnr_q;
  logic            rnr_ok;
  logic [RN_W-1:0] wr_idx;
  logic            base_we;
  logic            attr_we;
  logic [31:0]     rd_base;
  logic [15:0]     rd_size;
  logic [15:0]     rd_acc;

  mpu_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .kind (kind)
  );

  mpu_ctrl_regs #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind      (kind),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .rnr_q     (rnr_q),
    .rnr_ok    (rnr_ok),
    .wr_idx    (wr_idx),
    .base_we   (base_we),
    .attr_we   (attr_we),
    .flush_q   (flush_pulse),
    .illegal_q (illegal_pulse)
  );

  mpu_region_file #(.NUM_REGIONS(NUM_REGIONS)) u_regions (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_we  (base_we),
    .attr_we  (attr_we),
    .wr_idx   (wr_idx),
    .wdata    (bus_wdata),
    .rd_idx   (rnr_q),
    .rd_base  (rd_base),
    .rd_size  (rd_size),
    .rd_acc   (rd_acc),
    .base_all (region_base),
    .size_all (region_size),
    .acc_all  (region_access)
  );

  assign mpu_enable     = ctrl_q[0];
  assign mpu_fault_en   = ctrl_q[1];
  assign mpu_privdef_en = ctrl_q[2];

  always_comb begin
    bus_rdata = '0;
    case (kind)
      K_TYPE: bus_rdata = {16'b0, 8'(NUM_REGIONS), 8'b0};
      K_CTRL: bus_rdata = {29'b0, ctrl_q};
      K_RNR:  bus_rdata = {{(32-RN_W){1'b0}}, rnr_q};
      K_BASE: if (rnr_ok) bus_rdata = {rd_base[31:5], 1'b0, rnr_q};
      K_ATTR: if (rnr_ok) bus_rdata = {rd_acc, rd_size};
      default: bus_rdata = '0;
    endcase
  end

  assert_illegal_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == K_CTRL && bus_wdata[1] && !bus_wdata[0])
      |=> (illegal_pulse && flush_pulse));

  assert_flush_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(bus_wr));

  assert_type_no_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == K_TYPE) |=> !flush_pulse);

  assert_valid_sets_rnr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == K_BASE && bus_wdata[VALID_BIT] &&
     ({1'b0, bus_wdata[RN_W-1:0]} < NREG))
      |=> (rnr_q == $past(bus_wdata[RN_W-1:0])));

  assert_drop_no_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == K_BASE && bus_wdata[VALID_BIT] &&
     ({1'b0, bus_wdata[RN_W-1:0]} >= NREG))
      |=> (!flush_pulse && $stable(rnr_q)));

  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == K_NONE) |=> !flush_pulse);
endmodule

// File: tb/test_mpu_regbank.sv
`timescale 1ns/1ps
module test_mpu_regbank;
  localparam int N = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            mpu_enable, mpu_fault_en, mpu_privdef_en;
  logic [N*32-1:0] region_base;
  logic [N*16-1:0] region_size, region_access;
  logic            flush_pulse, illegal_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mpu_regbank #(.NUM_REGIONS(N), .ADDR_W(12)) i_mpu_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mpu_enable(mpu_enable),
    .mpu_fault_en(mpu_fault_en), .mpu_privdef_en(mpu_privdef_en),
    .region_base(region_base), .region_size(region_size),
    .region_access(region_access), .flush_pulse(flush_pulse),
    .illegal_pulse(illegal_pulse)
  );

  // behavioural reference state
  int unsigned m_ctrl, m_rnr, m_flush, m_illeg;
  int unsigned m_base [N];
  int unsigned m_size [N];
  int unsigned m_acc  [N];

  function automatic bit is_base(logic [11:0] a);
    return a == 12'hD9C || a == 12'hDA4 || a == 12'hDAC || a == 12'hDB4;
  endfunction
  function automatic bit is_attr(logic [11:0] a);
    return a == 12'hDA0 || a == 12'hDA8 || a == 12'hDB0 || a == 12'hDB8;
  endfunction

  function automatic int unsigned model_read(logic [11:0] a);
    if (a == 12'hD90) return N * 256;
    if (a == 12'hD94) return m_ctrl;
    if (a == 12'hD98) return m_rnr;
    if (is_base(a)) return (m_rnr < N) ? ((m_base[m_rnr] & 32'hFFFF_FFE0) | m_rnr) : 0;
    if (is_attr(a)) return (m_rnr < N) ? ((m_acc[m_rnr] << 16) | m_size[m_rnr]) : 0;
    return 0;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (a == 12'hD90) return "R2";
    if (a == 12'hD94) return "R3";
    if (a == 12'hD98) return "R5";
    if (is_base(a)) return "R7 R9";
    if (is_attr(a)) return "R8 R9";
    return "R11";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_rnr = 0; m_flush = 0; m_illeg = 0;
      for (int r = 0; r < N; r++) begin m_base[r] = 0; m_size[r] = 0; m_acc[r] = 0; end
    end else begin
      m_flush = 0; m_illeg = 0;
      if (bus_wr) begin
        if (bus_addr == 12'hD94) begin
          m_ctrl = bus_wdata & 7; m_flush = 1;
          m_illeg = ((bus_wdata & 3) == 2) ? 1 : 0;
        end else if (bus_addr == 12'hD98) begin
          if (bus_wdata < N) m_rnr = bus_wdata;
        end else if (is_base(bus_addr)) begin
          if (bus_wdata[4]) begin
            if ((bus_wdata & 15) < N) begin
              m_rnr = bus_wdata & 15;
              m_base[m_rnr] = bus_wdata & 32'hFFFF_FFE0; m_flush = 1;
            end
          end else if (m_rnr < N) begin
            m_base[m_rnr] = bus_wdata & 32'hFFFF_FFE0; m_flush = 1;
          end
        end else if (is_attr(bus_addr)) begin
          if (m_rnr < N) begin
            m_size[m_rnr] = bus_wdata & 32'h0000_FF3F;
            m_acc[m_rnr]  = (bus_wdata >> 16) & 32'h173F;
            m_flush = 1;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      int unsigned e;
      if (!rst_n) begin
        chk(flush_pulse == 0 && illegal_pulse == 0, "R1 pulses", {30'b0, flush_pulse, illegal_pulse}, 0);
      end else begin
        e = model_read(bus_addr);
        chk(bus_rdata == e, tag_of(bus_addr), bus_rdata, e);
        chk({mpu_privdef_en, mpu_fault_en, mpu_enable} == 3'(m_ctrl), "R3 ctrl pins",
            {29'b0, mpu_privdef_en, mpu_fault_en, mpu_enable}, m_ctrl);
        chk(flush_pulse == m_flush[0], "R10 flush", {31'b0, flush_pulse}, m_flush);
        chk(illegal_pulse == m_illeg[0], "R4 illegal", {31'b0, illegal_pulse}, m_illeg);
        for (int r = 0; r < N; r++) begin
          chk(region_base[r*32 +: 32] == m_base[r], "R7 base out", region_base[r*32 +: 32], m_base[r]);
          chk(region_size[r*16 +: 16] == 16'(m_size[r]), "R8 size out", {16'b0, region_size[r*16 +: 16]}, m_size[r]);
          chk(region_access[r*16 +: 16] == 16'(m_acc[r]), "R8 access out", {16'b0, region_access[r*16 +: 16]}, m_acc[r]);
        end
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1'b0;
    #2;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    logic [11:0] addr_set [14];
    addr_set = '{12'hD90, 12'hD94, 12'hD98, 12'hD9C, 12'hDA0, 12'hDA4, 12'hDA8,
                 12'hDAC, 12'hDB0, 12'hDB4, 12'hDB8, 12'hDBC, 12'hD8C, 12'h000};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(12'hD94, 32'h0, "R1 ctrl");
    rd(12'hD98, 32'h0, "R1 rnr");
    rd(12'hD9C, 32'h0, "R1 base");
    rd(12'hDA0, 32'h0, "R1 attr");
    chk(region_base == '0 && region_size == '0 && region_access == '0, "R1 regions", 32'(region_base[31:0]), 0);

    // R2 type word
    rd(12'hD90, 32'h0000_0800, "R2 type");
    wr(12'hD90, 32'hFFFF_FFFF);
    chk(flush_pulse == 1'b0, "R2 no flush", {31'b0, flush_pulse}, 0);
    rd(12'hD90, 32'h0000_0800, "R2 type after write");

    // R3 / R4 / R10
    wr(12'hD94, 32'hFFFF_FFFF);
    chk(flush_pulse == 1'b1, "R10 ctrl flush", {31'b0, flush_pulse}, 1);
    chk(illegal_pulse == 1'b0, "R4 legal", {31'b0, illegal_pulse}, 0);
    rd(12'hD94, 32'h7, "R3 keep three bits");
    wr(12'hD94, 32'h0000_0002);
    chk(illegal_pulse == 1'b1, "R4 illegal pulse", {31'b0, illegal_pulse}, 1);
    rd(12'hD94, 32'h2, "R4 stored anyway");
    chk(illegal_pulse == 1'b0, "R4 one cycle", {31'b0, illegal_pulse}, 0);

    // R5
    wr(12'hD98, 32'd3);
    rd(12'hD98, 32'd3, "R5 store");
    wr(12'hD98, 32'd8);
    rd(12'hD98, 32'd3, "R5 ignore 8");
    wr(12'hD98, 32'hFFFF_FFF0);
    rd(12'hD98, 32'd3, "R5 ignore large");

    // R7 implicit region, R6 own index, R9 aliases
    wr(12'hD9C, 32'h1234_566A);
    rd(12'hD9C, 32'h1234_5663, "R7 base read");
    wr(12'hDA4, 32'hABCD_EF15);
    rd(12'hD98, 32'd5, "R6 rnr from base");
    rd(12'hDB4, 32'hABCD_EF05, "R9 alias base");
    chk(region_base[5*32 +: 32] == 32'hABCD_EF00, "R6 base pin", region_base[5*32 +: 32], 32'hABCD_EF00);
    wr(12'hDAC, 32'h5555_5519);
    chk(flush_pulse == 1'b0, "R6 dropped no flush", {31'b0, flush_pulse}, 0);
    rd(12'hD98, 32'd5, "R6 dropped rnr");
    rd(12'hD9C, 32'hABCD_EF05, "R6 dropped base");

    // R8 attribute masking
    wr(12'hDA0, 32'hFFFF_FFFF);
    rd(12'hDB8, 32'h173F_FF3F, "R8 attr mask");
    wr(12'hD98, 32'd3);
    rd(12'hDA8, 32'h0, "R8 other region");
    rd(12'hDAC, 32'h1234_5663, "R9 alias base r3");

    // R11 unmapped
    rd(12'hD8C, 32'h0, "R11 read");
    wr(12'hDBC, 32'hFFFF_FFFF);
    chk(flush_pulse == 1'b0, "R11 no flush", {31'b0, flush_pulse}, 0);
    rd(12'hDBC, 32'h0, "R11 read after write");

    // pseudo-random stream, checked every clock by the model
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = addr_set[lfsr[7:0] % 14];
      d = lfsr * 32'h9E37_79B9;
      if (a == 12'hD98) d = {28'b0, d[3:0]};
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wr = lfsr[9];
    end
    @(posedge clk); #1 bus_wr = 1'b0;
    repeat (2) @(posedge clk);
    #3;
    finish_run();
  end
endmodule